// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block turns an integer texel coordinate into a byte offset inside a surface. The surface can be linear or tiled. The coordinate kinds are one-dimensional, two-dimensional, one-dimensional array, two-dimensional array and volume. The caller supplies every surface parameter alongside the coordinate:

- a position origin;
- log2 tile widths and heights, plus a slice-grouping shift;
- bytes per texel, the row pitch and two slice pitches;
- a size vector for the bounds check;
- two swizzle shift amounts with their enable;
- an enable for the raw-surface check.

Both tiling layouts are handled by one shift formula. A tall tile is described as a set of narrow wide-tiles placed side by side. The generator also reports whether the access may proceed. That decision comes from a signed bounds check and an optional bytes-per-texel check.

Each request is taken on a valid/ready handshake. The result is registered, so it appears one cycle after acceptance. The output side is a two-state machine:

- `ST_EMPTY` means no result is held. It moves to `ST_FULL` on accept.
- `ST_FULL` means a result is held. It returns to `ST_EMPTY` when the result leaves and no new request enters.
- While `ST_FULL`, accepting a new request in the same cycle that the result leaves keeps the state at `ST_FULL`.

Top module: `tile_addr_gen`

## Requirements
- R1: Kind code 0 (one-dimensional; codes 5 to 7 behave the same) yields addr = (org_y*row_pitch + coord_x + org_x) * bpp, with no swizzle, even when swizzle is enabled.
- R2: Kind code 1 (two-dimensional) uses px = coord_x+org_x and py = coord_y+org_y. It yields addr = (((py>>ty)<<ty)*row_pitch + ((((px>>tx)<<ty) + py mod 2^ty) << tx) + px mod 2^tx) * bpp.
- R3: Kind code 2 (one-dimensional array) takes the layer from coord_y, uses y = 0, and follows the three-component path of R4.
- R4: Kind codes 3 (two-dimensional array) and 4 (volume) first split the layer z. The low tz bits of z, multiplied by slice_pitch_x, are added to px. The value z>>tz, multiplied by slice_pitch_y, is added to py. The R2 formula then applies.
- R5: With swz_en set on a tiled kind, the swizzle bit is (((addr >> s0[4:0]) XOR (addr >> s1[4:0])) AND 0x40). That bit is XORed into addr, so a shift of 0xFF acts as 31.
- R6: With swz_en clear the unswizzled address is output. With both shifts at 0xFF the address is unchanged.
- R7: addr_ok requires every used coordinate to be signed-less than its size. One coordinate is used for kinds 0 and 5-7, x and y for kinds 1 and 2, and x, y and z for kinds 3 and 4.
- R8: With raw_chk_en set, addr_ok additionally requires bpp > 4 (signed).
- R9: The input is accepted when in_valid and in_ready are both high. The result appears on the next cycle with out_valid. in_ready = !out_valid || out_ready. A held result stays stable while out_ready is low.
- R10: After reset, out_valid, out_addr and out_ok are zero.
- R11: All arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_valid | input | 1 | request present |
| in_ready | output | 1 | request can be taken |
| kind | input | 3 | coordinate kind code (R1-R4 list the codes) |
| coord_x | input | 32 | coordinate x |
| coord_y | input | 32 | coordinate y or array layer |
| coord_z | input | 32 | coordinate z or array layer |
| org_x | input | 32 | origin added to x |
| org_y | input | 32 | origin added to y |
| tile_sx | input | 5 | log2 tile width in texels |
| tile_sy | input | 5 | log2 tile height in rows |
| tile_sz | input | 5 | log2 slices per slice row |
| bpp | input | 32 | bytes per texel |
| row_pitch | input | 32 | texels per row |
| slice_px | input | 32 | horizontal slice pitch |
| slice_py | input | 32 | vertical slice pitch |
| size_x | input | 32 | bound for x |
| size_y | input | 32 | bound for y |
| size_z | input | 32 | bound for z |
| swz_s0 | input | 8 | first swizzle shift |
| swz_s1 | input | 8 | second swizzle shift |
| swz_en | input | 1 | swizzle enable |
| raw_chk_en | input | 1 | raw-surface check enable |
| out_valid | output | 1 | result present |
| out_ready | input | 1 | result can leave |
| out_addr | output | 32 | byte offset |
| out_ok | output | 1 | access allowed |

## Verification
The hardest case to reach from the ports is a request that arrives while a result is held under back-pressure. It must be accepted in exactly the cycle the old result leaves, with the new one in place the next cycle. To reach it, the stimulus toggles out_ready at random while requests are offered back to back. A second hard case is the swizzle bit flipping only for particular address patterns. The stimulus covers it with tile shapes and shift pairs chosen so that bits 9 to 11 of the address vary. Negative coordinates and bytes-per-texel values on either side of 4 exercise the signed bound and the raw check.

// File: rtl/tag_pkg.sv
package tag_pkg;
    localparam int AW  = 32;
    localparam int SHW = 5;
    localparam int SWW = 8;

    typedef enum logic [2:0] {
        DIM_LINE      = 3'd0,
        DIM_PLANE     = 3'd1,
        DIM_LINE_ARR  = 3'd2,
        DIM_PLANE_ARR = 3'd3,
        DIM_VOLUME    = 3'd4
    } dim_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ost_e;
endpackage

// File: rtl/tag_coord_map.sv
module tag_coord_map
    import tag_pkg::*;
#(
    parameter int W = AW
) (
    input  logic [2:0]   kind,
    input  logic [W-1:0] cx,
    input  logic [W-1:0] cy,
    input  logic [W-1:0] cz,
    input  logic [W-1:0] sx,
    input  logic [W-1:0] sy,
    input  logic [W-1:0] sz,
    input  logic [W-1:0] bpp,
    input  logic         raw_en,
    output logic [W-1:0] mx,
    output logic [W-1:0] my,
    output logic [W-1:0] mz,
    output logic         has_z,
    output logic         linear,
    output logic         in_range
);
    logic lt_x, lt_y, lt_z, bounds_ok, raw_ok;

    assign lt_x = $signed(cx) < $signed(sx);
    assign lt_y = $signed(cy) < $signed(sy);
    assign lt_z = $signed(cz) < $signed(sz);

    always_comb begin
        mx = cx;
        my = '0;
        mz = '0;
        has_z = 1'b0;
        linear = 1'b0;
        bounds_ok = lt_x;
        unique case (kind)
            DIM_PLANE: begin
                my = cy;
                bounds_ok = lt_x & lt_y;
            end
            DIM_LINE_ARR: begin
                mz = cy;
                has_z = 1'b1;
                bounds_ok = lt_x & lt_y;
            end
            DIM_PLANE_ARR, DIM_VOLUME: begin
                my = cy;
                mz = cz;
                has_z = 1'b1;
                bounds_ok = lt_x & lt_y & lt_z;
            end
            default: begin
                linear = 1'b1;
            end
        endcase
    end

    assign raw_ok   = !raw_en || ($signed(bpp) > $signed(W'(4)));
    assign in_range = bounds_ok & raw_ok;
endmodule

// File: rtl/tag_tile_index.sv
module tag_tile_index
    import tag_pkg::*;
#(
    parameter int W  = AW,
    parameter int SW = SHW
) (
    input  logic [W-1:0]  mx,
    input  logic [W-1:0]  my,
    input  logic [W-1:0]  mz,
    input  logic          has_z,
    input  logic          linear,
    input  logic [W-1:0]  org_x,
    input  logic [W-1:0]  org_y,
    input  logic [SW-1:0] tsx,
    input  logic [SW-1:0] tsy,
    input  logic [SW-1:0] tsz,
    input  logic [W-1:0]  bpp,
    input  logic [W-1:0]  pitch,
    input  logic [W-1:0]  slice_px,
    input  logic [W-1:0]  slice_py,
    output logic [W-1:0]  addr
);
    logic [W-1:0] px0, py0, px, py;
    logic [W-1:0] z_lo, z_hi;
    logic [W-1:0] min_x, min_y, maj_x, maj_y;
    logic [W-1:0] hidx, vidx, texel;

    assign px0  = mx + org_x;
    assign py0  = my + org_y;
    assign z_lo = mz & ((W'(1) << tsz) - W'(1));
    assign z_hi = mz >> tsz;
    assign px   = has_z ? px0 + z_lo * slice_px : px0;
    assign py   = has_z ? py0 + z_hi * slice_py : py0;

    assign min_x = px & ((W'(1) << tsx) - W'(1));
    assign min_y = py & ((W'(1) << tsy) - W'(1));
    assign maj_x = px >> tsx;
    assign maj_y = py >> tsy;
    assign hidx  = ((((maj_x << tsy) + min_y) << tsx) + min_x);
    assign vidx  = maj_y << tsy;

    assign texel = linear ? (py * pitch + px) : (vidx * pitch + hidx);
    assign addr  = texel * bpp;
endmodule

// File: rtl/tag_swizzle.sv
module tag_swizzle
    import tag_pkg::*;
#(
    parameter int W  = AW,
    parameter int SS = SWW,
    parameter int XB = 6
) (
    input  logic [W-1:0]  addr_in,
    input  logic [SS-1:0] s0,
    input  logic [SS-1:0] s1,
    input  logic          en,
    output logic [W-1:0]  addr_out
);
    localparam int LW = $clog2(W);
    logic [W-1:0] t0, t1, flip;

    assign t0   = addr_in >> s0[LW-1:0];
    assign t1   = addr_in >> s1[LW-1:0];
    assign flip = (t0 ^ t1) & (W'(1) << XB);
    assign addr_out = en ? (addr_in ^ flip) : addr_in;
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
    import tag_pkg::*;
#(
    parameter int W  = AW,
    parameter int SW = SHW,
    parameter int SS = SWW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [2:0]    kind,
    input  logic [W-1:0]  coord_x,
    input  logic [W-1:0]  coord_y,
    input  logic [W-1:0]  coord_z,
    input  logic [W-1:0]  org_x,
    input  logic [W-1:0]  org_y,
    input  logic [SW-1:0] tile_sx,
    input  logic [SW-1:0] tile_sy,
    input  logic [SW-1:0] tile_sz,
    input  logic [W-1:0]  bpp,
    input  logic [W-1:0]  row_pitch,
    input  logic [W-1:0]  slice_px,
    input  logic [W-1:0]  slice_py,
    input  logic [W-1:0]  size_x,
    input  logic [W-1:0]  size_y,
    input  logic [W-1:0]  size_z,
    input  logic [SS-1:0] swz_s0,
    input  logic [SS-1:0] swz_s1,
    input  logic          swz_en,
    input  logic          raw_chk_en,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [W-1:0]  out_addr,
    output logic          out_ok
);
    logic [W-1:0] mx, my, mz, pre_addr, fin_addr;
    logic         has_z, linear, in_range, accept;
    ost_e         state_q, state_d;

    tag_coord_map #(.W(W)) u_map (
        .kind(kind), .cx(coord_x), .cy(coord_y), .cz(coord_z),
        .sx(size_x), .sy(size_y), .sz(size_z), .bpp(bpp), .raw_en(raw_chk_en),
        .mx(mx), .my(my), .mz(mz), .has_z(has_z), .linear(linear),
        .in_range(in_range)
    );

    tag_tile_index #(.W(W), .SW(SW)) u_idx (
        .mx(mx), .my(my), .mz(mz), .has_z(has_z), .linear(linear),
        .org_x(org_x), .org_y(org_y), .tsx(tile_sx), .tsy(tile_sy), .tsz(tile_sz),
        .bpp(bpp), .pitch(row_pitch), .slice_px(slice_px), .slice_py(slice_py),
        .addr(pre_addr)
    );

    tag_swizzle #(.W(W), .SS(SS)) u_swz (
        .addr_in(pre_addr), .s0(swz_s0), .s1(swz_s1),
        .en(swz_en & ~linear), .addr_out(fin_addr)
    );

    assign in_ready  = (state_q == ST_EMPTY) || out_ready;
    assign accept    = in_valid && in_ready;
    assign out_valid = (state_q == ST_FULL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !accept) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_ok   <= 1'b0;
        end else if (accept) begin
            out_addr <= fin_addr;
            out_ok   <= in_range;
        end
    end
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic [2:0]   kind,
    input logic [W-1:0] coord_x,
    input logic [W-1:0] size_x,
    input logic [W-1:0] bpp,
    input logic         raw_chk_en,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_addr,
    input logic         out_ok
);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_ok));

    p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    p_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && raw_chk_en && ($signed(bpp) <= 4) |=> !out_ok);

    p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (kind == 3'd1) && ($signed(coord_x) >= $signed(size_x))
        |=> !out_ok);
endmodule

bind tile_addr_gen tile_addr_gen_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .kind(kind), .coord_x(coord_x), .size_x(size_x), .bpp(bpp),
    .raw_chk_en(raw_chk_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_ok(out_ok)
);

// File: tb/sim_tile_addr_gen.sv
module sim_tile_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0, out_ok;
    logic [2:0] kind = '0;
    logic [31:0] coord_x = '0, coord_y = '0, coord_z = '0, org_x = '0, org_y = '0;
    logic [4:0] tile_sx = '0, tile_sy = '0, tile_sz = '0;
    logic [31:0] bpp = 32'd1, row_pitch = '0, slice_px = '0, slice_py = '0;
    logic [31:0] size_x = '0, size_y = '0, size_z = '0, out_addr;
    logic [7:0] swz_s0 = 8'hFF, swz_s1 = 8'hFF;
    logic swz_en = 1'b0, raw_chk_en = 1'b0;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 1'b0;
    string cur_tag = "R2";
    int unsigned q_addr[$];
    bit q_ok[$];
    string q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_addr_gen u0 (.*);

    function automatic int unsigned ref_addr();
        int unsigned x, y, z, px, py, wx, wy, dz, a, t;
        bit zed, lin;
        x = coord_x; y = 0; z = 0; zed = 0; lin = 0;
        case (kind)
            3'd1: y = coord_y;
            3'd2: begin z = coord_y; zed = 1; end
            3'd3, 3'd4: begin y = coord_y; z = coord_z; zed = 1; end
            default: lin = 1;
        endcase
        px = x + org_x;
        py = y + org_y;
        if (zed) begin
            dz = 32'd1 << tile_sz;
            px = px + (z % dz) * slice_px;
            py = py + (z / dz) * slice_py;
        end
        if (lin) return (py * row_pitch + px) * bpp;
        wx = 32'd1 << tile_sx;
        wy = 32'd1 << tile_sy;
        a = (((py / wy) * wy) * row_pitch + ((px / wx) * wy + py % wy) * wx + px % wx) * bpp;
        if (swz_en) begin
            t = (a >> (swz_s0 % 32)) ^ (a >> (swz_s1 % 32));
            if ((t & 32'h40) != 0) a = a ^ 32'h40;
        end
        return a;
    endfunction

    function automatic bit ref_ok();
        int n;
        bit ok;
        n = (kind == 3'd1 || kind == 3'd2) ? 2 : (kind == 3'd3 || kind == 3'd4) ? 3 : 1;
        ok = $signed(coord_x) < $signed(size_x);
        if (n > 1) ok = ok && ($signed(coord_y) < $signed(size_y));
        if (n > 2) ok = ok && ($signed(coord_z) < $signed(size_z));
        if (raw_chk_en) ok = ok && ($signed(bpp) > 4);
        return ok;
    endfunction

    // monitor: compares and records at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid && out_ready) begin
                checks++;
                if (q_addr.size() == 0) begin
                    failures++;
                    $display("FAIL R9 unexpected result addr=%0h expected none", out_addr);
                end else begin
                    if (out_addr !== q_addr[0] || out_ok !== q_ok[0]) begin
                        failures++;
                        $display("FAIL %s addr=%0h ok=%0b expected addr=%0h ok=%0b",
                                 q_tag[0], out_addr, out_ok, q_addr[0], q_ok[0]);
                    end
                    void'(q_addr.pop_front()); void'(q_ok.pop_front()); void'(q_tag.pop_front());
                end
            end
            if (in_valid && in_ready) begin
                q_addr.push_back(ref_addr());
                q_ok.push_back(ref_ok());
                q_tag.push_back(cur_tag);
            end
        end
    end

    // random back-pressure
    always @(posedge clk) begin
        #1 out_ready <= ($urandom_range(0, 9) < 7);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic send(input string tag);
        bit acc;
        cur_tag = tag;
        in_valid = 1'b1;
        acc = 1'b0;
        while (!acc) begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #2;
        end
        in_valid = 1'b0;
    endtask

    task automatic surf(input int sx, input int sy, input int sz, input int bp, input int pit);
        tile_sx = 5'(sx); tile_sy = 5'(sy); tile_sz = 5'(sz);
        bpp = bp; row_pitch = pit;
        slice_px = 32'd64; slice_py = 32'd16;
        size_x = 32'd1000; size_y = 32'd1000; size_z = 32'd1000;
        org_x = '0; org_y = '0; swz_en = 1'b0; raw_chk_en = 1'b0;
        swz_s0 = 8'hFF; swz_s1 = 8'hFF;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_addr !== 32'd0 || out_ok !== 1'b0) begin
            failures++;
            $display("FAIL R10 valid=%0b addr=%0h ok=%0b expected 0 0 0", out_valid, out_addr, out_ok);
        end
        @(posedge clk); #2;

        // R1 one-dimensional, swizzle request ignored
        surf(3, 2, 0, 4, 100);
        kind = 3'd0; coord_x = 32'd17; org_x = 32'd3; org_y = 32'd2;
        swz_en = 1'b1; swz_s0 = 8'd9; swz_s1 = 8'd10;
        send("R1");
        kind = 3'd6; coord_x = 32'd40; send("R1");
        // R2 two-dimensional tiled
        surf(3, 2, 0, 4, 128);
        kind = 3'd1; coord_x = 32'd21; coord_y = 32'd13; org_x = 32'd5; org_y = 32'd1;
        send("R2");
        surf(7, 3, 0, 1, 512);
        coord_x = 32'd300; coord_y = 32'd77; send("R2");
        // R3 one-dimensional array
        surf(4, 3, 2, 2, 64);
        kind = 3'd2; coord_x = 32'd9; coord_y = 32'd6; org_y = 32'd4; send("R3");
        // R4 array and volume slice split
        kind = 3'd3; coord_x = 32'd5; coord_y = 32'd3; coord_z = 32'd7; send("R4");
        kind = 3'd4; coord_z = 32'd13; send("R4");
        // R5 swizzle with shift pairs, R6 disabled
        surf(7, 3, 0, 4, 512);
        kind = 3'd1; coord_x = 32'd100; coord_y = 32'd9;
        swz_en = 1'b1; swz_s0 = 8'd3; swz_s1 = 8'd4; send("R5");
        swz_s0 = 8'd5; swz_s1 = 8'hFF; send("R5");
        swz_s0 = 8'hFF; swz_s1 = 8'hFF; send("R6");
        swz_en = 1'b0; swz_s0 = 8'd3; swz_s1 = 8'd4; send("R6");
        // R7 signed bounds
        surf(2, 2, 0, 4, 64);
        kind = 3'd1; coord_x = 32'hFFFF_FFFF; coord_y = 32'd0; size_x = 32'd4; send("R7");
        coord_x = 32'd4; send("R7");
        coord_x = 32'd3; coord_y = 32'd4; size_y = 32'd4; send("R7");
        kind = 3'd0; send("R7");
        kind = 3'd3; coord_y = 32'd1; coord_z = 32'd9; size_z = 32'd9; send("R7");
        // R8 raw check
        surf(2, 2, 0, 4, 64);
        kind = 3'd1; coord_x = 32'd1; coord_y = 32'd1; raw_chk_en = 1'b1; send("R8");
        bpp = 32'd8; send("R8");
        bpp = 32'hFFFF_FFF0; send("R8");
        // R11 wrap
        surf(3, 3, 0, 16, 32'h4000_0000);
        kind = 3'd1; coord_x = 32'd5; coord_y = 32'd77; send("R11");

        // R9 random traffic under back-pressure
        for (int i = 0; i < 400; i++) begin
            surf($urandom_range(0, 7), $urandom_range(0, 5), $urandom_range(0, 3),
                 $urandom_range(1, 16), $urandom_range(1, 4096));
            kind = 3'($urandom_range(0, 7));
            coord_x = $urandom_range(0, 1200) - 100;
            coord_y = $urandom_range(0, 1200) - 100;
            coord_z = $urandom_range(0, 1200) - 100;
            org_x = $urandom_range(0, 50); org_y = $urandom_range(0, 50);
            slice_px = $urandom_range(0, 300); slice_py = $urandom_range(0, 300);
            swz_en = $urandom_range(0, 1);
            swz_s0 = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 12));
            swz_s1 = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 12));
            raw_chk_en = $urandom_range(0, 1);
            send("R9");
        end

        while (q_addr.size() != 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule